// File: doc/BRIEF.md
# Serial Control-DAC Command Port

This block is a three-wire serial slave that sits next to a bank of video column amplifiers and two slow control DACs. A host frames each transfer with an active-low select line. While select is low, the host presents one data bit per rising edge of a serial clock. Each transfer carries a 12-bit command word, and the block acts on it when select is released.

The two top bits of the word are an opcode. One opcode loads the first control-DAC code and, in the same step, takes the part out of grounded mode. Another loads the second control-DAC code. The remaining two opcodes put the part into grounded mode or take it out, without touching either code. When grounded mode is in effect, the video outputs and the first control DAC are pulled to ground. A test input held high overrides the programmed state and forces normal operation.

The serial lines are asynchronous to the block clock. The block brings them in through synchronizers and finds their edges in the clock domain, so the serial clock must run well below the block clock.

Top module: `ctl_dac_port`

## Requirements
- R1: After reset both DAC codes read 0 and the programmed state is grounded, so `gnd_force` is 1 while `test_force` is low.
- R2: A word is the last 12 bits shifted in while `sel_n` is low, sent with bit 11 first. Bits 7..0 form the DAC code with bit 7 as the MSB. Bits 9..8 have no effect.
- R3: Opcode {bit11,bit10}=00 writes bits 7..0 to `dac2_code` and leaves `dac1_code` and the grounded state unchanged.
- R4: Opcode 10 writes bits 7..0 to `dac1_code`, leaves grounded mode, and leaves `dac2_code` unchanged.
- R5: Opcode 01 leaves grounded mode and changes neither DAC code.
- R6: Opcode 11 enters grounded mode and changes neither DAC code.
- R7: A word takes effect only on the rising edge of `sel_n`. Serial clock edges while `sel_n` is high change no output.
- R8: A transfer of more than 12 clocks executes the last 12 bits received.
- R9: A transfer of fewer than 12 clocks changes no output.
- R10: `gnd_force` is 0 whenever `test_force` is 1. Otherwise it follows the programmed grounded state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Serial select, low during a transfer |
| sck | input | 1 | Serial clock, data taken on rising edge |
| sdi | input | 1 | Serial data |
| test_force | input | 1 | High forces normal (non-grounded) operation |
| dac1_code | output | 8 | First control-DAC code |
| dac2_code | output | 8 | Second control-DAC code |
| gnd_force | output | 1 | Grounds the video outputs and the first control DAC |

## Verification
The hardest cases to reach are transfers of the wrong length. In these, the bit counter and the shift register disagree with what a well-behaved host would send. The stimulus sends a 16-clock transfer whose last 12 bits hold a valid opcode with leading junk. It also sends an 11-clock transfer that would change state if it were executed. A third case toggles the serial clock and data while select is high, then reads every output to confirm nothing moved. Each case is followed by a legal word, so the check also confirms the receiver recovers.

// File: rtl/ctl_dac_pkg.sv
package ctl_dac_pkg;
  typedef enum logic [1:0] {
    OP_LOAD2   = 2'b00,
    OP_GND_OFF = 2'b01,
    OP_LOAD1   = 2'b10,
    OP_GND_ON  = 2'b11
  } op_e;
endpackage

// File: rtl/ctl_dac_sync.sv
module ctl_dac_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] stg_d [STAGES];

  always_comb begin
    stg_d[0] = d;
    for (int i = 1; i < STAGES; i++) stg_d[i] = stg_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= stg_d[i];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/ctl_dac_rx.sv
module ctl_dac_rx #(
  parameter int WORD_BITS = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sel_s,
  input  logic                 sck_s,
  input  logic                 sdi_s,
  output logic                 exec_o,
  output logic [WORD_BITS-1:0] word_o
);
  localparam int CW = $clog2(WORD_BITS + 1);
  localparam logic [CW-1:0] FULL = CW'(WORD_BITS);

  logic                 sel_q, sel_d;
  logic                 sck_q, sck_d;
  logic [WORD_BITS-1:0] shr_q, shr_d;
  logic [CW-1:0]        cnt_q, cnt_d;
  logic                 sel_fall, sel_rise, sck_rise;

  assign sel_fall = sel_q & ~sel_s;
  assign sel_rise = ~sel_q & sel_s;
  assign sck_rise = ~sck_q & sck_s & ~sel_s;

  always_comb begin
    sel_d = sel_s;
    sck_d = sck_s;
    shr_d = shr_q;
    cnt_d = cnt_q;
    if (sck_rise) begin
      shr_d = {shr_q[WORD_BITS-2:0], sdi_s};
      if (cnt_q != FULL) cnt_d = cnt_q + 1'b1;
    end
    if (sel_fall) cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b1;
      sck_q <= 1'b0;
      shr_q <= '0;
      cnt_q <= '0;
    end else begin
      sel_q <= sel_d;
      sck_q <= sck_d;
      shr_q <= shr_d;
      cnt_q <= cnt_d;
    end
  end

  assign exec_o = sel_rise && (cnt_q == FULL);
  assign word_o = shr_q;

  // R9
  short_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_rise && cnt_q != FULL) |-> !exec_o);
  // R7
  idle_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_s && sel_q) |=> $stable(cnt_q) && $stable(shr_q));
endmodule

// File: rtl/ctl_dac_regs.sv
module ctl_dac_regs
  import ctl_dac_pkg::*;
#(
  parameter int WORD_BITS = 12,
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 exec_i,
  input  logic [WORD_BITS-1:0] word_i,
  output logic [DATA_BITS-1:0] dac1_o,
  output logic [DATA_BITS-1:0] dac2_o,
  output logic                 gnd_o
);
  op_e                  op;
  logic [DATA_BITS-1:0] dat;
  logic [DATA_BITS-1:0] d1_q, d1_d, d2_q, d2_d;
  logic                 g_q, g_d;

  assign op  = op_e'(word_i[WORD_BITS-1 -: 2]);
  assign dat = word_i[DATA_BITS-1:0];

  always_comb begin
    d1_d = d1_q;
    d2_d = d2_q;
    g_d  = g_q;
    if (exec_i) begin
      unique case (op)
        OP_LOAD2:   d2_d = dat;
        OP_LOAD1:   begin d1_d = dat; g_d = 1'b0; end
        OP_GND_OFF: g_d = 1'b0;
        OP_GND_ON:  g_d = 1'b1;
        default:    g_d = g_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d1_q <= '0;
      d2_q <= '0;
      g_q  <= 1'b1;
    end else begin
      d1_q <= d1_d;
      d2_q <= d2_d;
      g_q  <= g_d;
    end
  end

  assign dac1_o = d1_q;
  assign dac2_o = d2_q;
  assign gnd_o  = g_q;

  // R7
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_i |=> $stable(d1_q) && $stable(d2_q) && $stable(g_q));
  // R3
  load2_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && op == OP_LOAD2) |=> $stable(d1_q) && $stable(g_q));
  // R5
  gnd_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && op == OP_GND_OFF) |=> !g_q && $stable(d1_q) && $stable(d2_q));
  // R6
  gnd_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && op == OP_GND_ON) |=> g_q && $stable(d1_q) && $stable(d2_q));
endmodule

// File: rtl/ctl_dac_port.sv
module ctl_dac_port #(
  parameter int WORD_BITS   = 12,
  parameter int DATA_BITS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sel_n,
  input  logic                 sck,
  input  logic                 sdi,
  input  logic                 test_force,
  output logic [DATA_BITS-1:0] dac1_code,
  output logic [DATA_BITS-1:0] dac2_code,
  output logic                 gnd_force
);
  logic [2:0]           lines_s;
  logic                 exec;
  logic [WORD_BITS-1:0] word;
  logic                 gnd_prog;

  ctl_dac_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({sel_n, sck, sdi}), .q(lines_s)
  );

  ctl_dac_rx #(.WORD_BITS(WORD_BITS)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .sel_s(lines_s[2]), .sck_s(lines_s[1]), .sdi_s(lines_s[0]),
    .exec_o(exec), .word_o(word)
  );

  ctl_dac_regs #(.WORD_BITS(WORD_BITS), .DATA_BITS(DATA_BITS)) u_regs (
    .clk(clk), .rst_n(rst_n), .exec_i(exec), .word_i(word),
    .dac1_o(dac1_code), .dac2_o(dac2_code), .gnd_o(gnd_prog)
  );

  assign gnd_force = gnd_prog & ~test_force;

  // R10
  test_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
    test_force |-> !gnd_force);
endmodule

// File: tb/ctl_dac_port_bench.sv
module ctl_dac_port_bench;
  typedef struct {
    logic [7:0] d1;
    logic [7:0] d2;
    logic       g;
    string      tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_n = 1'b1, sck = 1'b0, sdi = 1'b0, test_force = 1'b0;
  logic [7:0] dac1_code, dac2_code;
  logic gnd_force;

  int checks = 0, failures = 0;
  bit done = 0;
  exp_t q[$];
  logic [7:0] m_d1 = 8'h00, m_d2 = 8'h00;
  logic m_g = 1'b1;

  always #4 clk = ~clk;

  ctl_dac_port u_ctl_dac_port (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sck(sck), .sdi(sdi),
    .test_force(test_force), .dac1_code(dac1_code), .dac2_code(dac2_code),
    .gnd_force(gnd_force)
  );

  task automatic check_now(string tag, logic [7:0] e1, logic [7:0] e2, logic eg);
    checks++;
    if (dac1_code !== e1 || dac2_code !== e2 || gnd_force !== eg) begin
      failures++;
      $display("FAIL %s actual d1=%h d2=%h g=%b expected d1=%h d2=%h g=%b",
               tag, dac1_code, dac2_code, gnd_force, e1, e2, eg);
    end
  endtask

  task automatic push(string tag);
    exp_t e;
    e.d1 = m_d1; e.d2 = m_d2; e.g = m_g & ~test_force; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic xfer(logic [31:0] bits, int n);
    @(negedge clk); sel_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = bits[i];
      repeat (4) @(negedge clk);
      sck = 1'b1;
      repeat (4) @(negedge clk);
      sck = 1'b0;
    end
    repeat (4) @(negedge clk);
    sel_n = 1'b1;
  endtask

  task automatic model(logic [11:0] w);
    case (w[11:10])
      2'b00: m_d2 = w[7:0];
      2'b10: begin m_d1 = w[7:0]; m_g = 1'b0; end
      2'b01: m_g = 1'b0;
      default: m_g = 1'b1;
    endcase
  endtask

  task automatic send(logic [11:0] w, string tag);
    xfer({20'd0, w}, 12);
    model(w);
    push(tag);
    repeat (20) @(negedge clk);
  endtask

  initial begin : monitor
    forever begin
      wait (q.size() != 0);
      repeat (10) @(negedge clk);
      begin
        exp_t e;
        e = q.pop_front();
        check_now(e.tag, e.d1, e.d2, e.g);
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_now("R1 reset", 8'h00, 8'h00, 1'b1);

    send(12'b00_11_1010_0101, "R3 load dac2, R2 bits 9:8 ignored");
    send(12'b10_00_1100_0011, "R4 load dac1 releases ground");
    send(12'b11_00_1111_1111, "R6 enter ground");
    send(12'b01_11_0000_0001, "R5 release ground");
    send(12'b00_01_1000_0000, "R2 msb first dac2");
    send(12'b10_10_0000_0001, "R4 dac1 lsb");

    // R7: clocks while select is high
    for (int i = 0; i < 6; i++) begin
      sdi = i[0];
      repeat (3) @(negedge clk); sck = 1'b1;
      repeat (3) @(negedge clk); sck = 1'b0;
    end
    repeat (10) @(negedge clk);
    check_now("R7 idle clocks ignored", m_d1, m_d2, m_g);

    // R8: 16 clocks, last 12 are opcode 10 with 0x5A
    xfer({16'd0, 4'b1111, 12'b10_00_0101_1010}, 16);
    model(12'b10_00_0101_1010);
    push("R8 long transfer");
    repeat (20) @(negedge clk);

    send(12'b11_00_0000_0000, "R6 ground again");

    // R9: 11 clocks of a word that would release ground
    xfer({21'd0, 11'b1_00_1110_0111}, 11);
    push("R9 short transfer discarded");
    repeat (20) @(negedge clk);

    // R10
    test_force = 1'b1;
    repeat (2) @(negedge clk);
    check_now("R10 test forces normal", m_d1, m_d2, 1'b0);
    send(12'b00_00_0011_1100, "R10 load under test");
    test_force = 1'b0;
    repeat (2) @(negedge clk);
    check_now("R10 programmed ground returns", m_d1, m_d2, m_g);

    send(12'b01_00_0000_0000, "R5 release after recovery");

    wait (q.size() == 0);
    repeat (15) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule